// File: doc/BRIEF.md
# Tick-aligned asynchronous serial transmitter

This block serialises one character at a time onto an idle-high line. A shared 16x oversampling tick feeds a divide-by-16 counter inside the block, and every bit boundary falls on an overflow of that counter. A queued character leaves only at such an overflow. The run enable must be high and the one-entry transmit buffer must hold data at that moment. When the character leaves, the buffer contents move into a frame register and the buffer is marked empty again, so software can queue the next character while the current one is still on the line.

A character can be sent in five frame formats. The two 8-bit formats carry either eight data bits, or seven data bits followed by a parity bit. The three 9-bit formats carry nine data bits, or eight data bits followed by parity, or eight data bits followed by a wake-up flag. The wake-up flag is taken from bit 8 of the written word: 1 marks an address frame and 0 marks a data frame. A one-cycle done pulse is raised at the end of the final stop bit. Dropping the run enable abandons the current frame at once, and the line returns to high.

Top module: `uart_tick_tx`

## Requirements
- R1: After reset, txd_o is 1, buf_empty_o is 1 and tx_done_o is 0.
- R2: Each bit lasts exactly 16 tick16_i pulses. A frame starts only on the counter overflow (the 16th tick since the counter was last cleared), and only while run_i is 1 and the buffer is full. With run_i low, nothing is sent and the buffer is kept.
- R3: A frame is one low start bit, then its payload least significant bit first, then one high stop bit (two_stop_i=0) or two high stop bits (two_stop_i=1). two_stop_i and mode_i are sampled when the frame starts.
- R4: mode_i=0 sends wr_data_i[7:0]. mode_i=1 sends wr_data_i[6:0] followed by a parity bit over those seven bits.
- R5: mode_i=2 sends all nine bits, wr_data_i[8:0].
- R6: mode_i=3 sends wr_data_i[7:0] followed by a parity bit over those eight bits. Parity makes the count of ones (data plus parity) even when odd_par_i=0 and odd when odd_par_i=1. The same rule applies to mode_i=1.
- R7: mode_i=4 sends wr_data_i[7:0] followed by a wake-up bit equal to wr_data_i[8]: 1 for an address frame, 0 for a data frame.
- R8: buf_empty_o falls in the cycle after a wr_i strobe. It rises in the cycle after the overflow that starts a frame, unless a write arrives on that same edge. A character written before the current frame ends follows it with no idle time on the line.
- R9: tx_done_o is a single-cycle pulse in the cycle after the overflow that ends the last stop bit.
- R10: When run_i is 0, txd_o is 1 from the next cycle on. Any frame in progress is dropped without a done pulse, and the tick counter is cleared.
- R11: mode_i values 5 to 7 behave as mode_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | 16x oversampling tick, one cycle wide |
| run_i | input | 1 | Transmitter run enable |
| mode_i | input | 3 | Frame format select (0..4, others as 0) |
| odd_par_i | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop_i | input | 1 | 1 = two stop bits, 0 = one stop bit |
| wr_i | input | 1 | Transmit buffer write strobe |
| wr_data_i | input | 9 | Character written to the transmit buffer |
| txd_o | output | 1 | Serial line, idles high |
| buf_empty_o | output | 1 | Transmit buffer is free |
| tx_done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench compares the line, the empty flag and the done pulse with its model on every clock. A wrong counter phase or bit index therefore shows up as a wrong line level no later than the next tick overflow. A bad frame length or a wrong parity choice shows up within one frame. A buffer handoff error shows up in the empty flag one cycle after the overflow that starts the frame. An abort that leaves state behind shows up when run is raised again, as a line that does not stay idle or a spurious done pulse.

// File: rtl/uart_tick_tx_pkg.sv
package uart_tick_tx_pkg;
  localparam int unsigned BUF_W   = 9;
  localparam int unsigned FRAME_W = 12;  // start + 9 + 2 stop
  localparam int unsigned IDX_W   = $clog2(FRAME_W);

  typedef enum logic [2:0] {
    FMT_8D      = 3'd0,
    FMT_7D_PAR  = 3'd1,
    FMT_9D      = 3'd2,
    FMT_8D_PAR  = 3'd3,
    FMT_8D_WAKE = 3'd4
  } tx_fmt_e;
endpackage

// File: rtl/uart_tick_tx_div.sv
module uart_tick_tx_div #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic ovf_o
);
  localparam int unsigned CW = $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign ovf_o = run_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_tick_tx_frame.sv
module uart_tick_tx_frame
  import uart_tick_tx_pkg::*;
(
  input  logic [BUF_W-1:0]   data_i,
  input  tx_fmt_e            fmt_i,
  input  logic               odd_i,
  input  logic               two_stop_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [IDX_W-1:0]   nbits_o
);
  logic par7, par8;
  int unsigned payload;

  assign par7 = (^data_i[6:0]) ^ odd_i;
  assign par8 = (^data_i[7:0]) ^ odd_i;

  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    payload    = 8;
    unique case (fmt_i)
      FMT_7D_PAR: begin
        frame_o[7:1] = data_i[6:0];
        frame_o[8]   = par7;
      end
      FMT_9D, FMT_8D_WAKE: begin
        frame_o[9:1] = data_i[8:0];
        payload      = 9;
      end
      FMT_8D_PAR: begin
        frame_o[8:1] = data_i[7:0];
        frame_o[9]   = par8;
        payload      = 9;
      end
      default: frame_o[8:1] = data_i[7:0];
    endcase
    nbits_o = IDX_W'(1 + payload + (two_stop_i ? 2 : 1));
  end
endmodule

// File: rtl/uart_tick_tx_seq.sv
module uart_tick_tx_seq
  import uart_tick_tx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               ovf_i,
  input  logic               have_data_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [IDX_W-1:0]   nbits_i,
  output logic               load_o,
  output logic               txd_o,
  output logic               done_o
);
  logic               busy_q, done_q;
  logic [IDX_W-1:0]   idx_q, nbits_q;
  logic [FRAME_W-1:0] frame_q;
  logic               last;

  assign last   = busy_q & (idx_q == nbits_q - 1'b1);
  assign load_o = run_i & ovf_i & have_data_i & (~busy_q | last);
  assign txd_o  = busy_q ? frame_q[idx_q] : 1'b1;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      nbits_q <= '0;
      frame_q <= '1;
      done_q  <= 1'b0;
    end else begin
      done_q <= run_i & ovf_i & last;
      if (!run_i) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (ovf_i) begin
        if (load_o) begin
          busy_q  <= 1'b1;
          idx_q   <= '0;
          frame_q <= frame_i;
          nbits_q <= nbits_i;
        end else if (last) begin
          busy_q <= 1'b0;
        end else if (busy_q) begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R2
  start_on_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txd_o) |-> $past(ovf_i));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_on_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ovf_i));
  // R10
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> txd_o);
endmodule

// File: rtl/uart_tick_tx.sv
module uart_tick_tx
  import uart_tick_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick16_i,
  input  logic             run_i,
  input  logic [2:0]       mode_i,
  input  logic             odd_par_i,
  input  logic             two_stop_i,
  input  logic             wr_i,
  input  logic [BUF_W-1:0] wr_data_i,
  output logic             txd_o,
  output logic             buf_empty_o,
  output logic             tx_done_o
);
  logic               ovf, load, full_q;
  logic [BUF_W-1:0]   buf_q;
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   nbits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (wr_i)      full_q <= 1'b1;
      else if (load) full_q <= 1'b0;
      if (wr_i)      buf_q  <= wr_data_i;
    end
  end
  assign buf_empty_o = ~full_q;

  uart_tick_tx_div #(.TICKS(TICKS_PER_BIT)) u_div (
    .clk_i, .rst_ni, .run_i, .tick_i(tick16_i), .ovf_o(ovf)
  );

  uart_tick_tx_frame u_frame (
    .data_i(buf_q), .fmt_i(tx_fmt_e'(mode_i)), .odd_i(odd_par_i),
    .two_stop_i, .frame_o(frame), .nbits_o(nbits)
  );

  uart_tick_tx_seq u_seq (
    .clk_i, .rst_ni, .run_i, .ovf_i(ovf), .have_data_i(full_q),
    .frame_i(frame), .nbits_i(nbits), .load_o(load),
    .txd_o, .done_o(tx_done_o)
  );

  // R8
  empty_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_empty_o) |-> $past(load));
  // R8
  write_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !buf_empty_o);
endmodule

// File: tb/uart_tick_tx_bench.sv
`timescale 1ns/1ps
module uart_tick_tx_bench;
  logic clk = 0, rst_ni = 0, tick = 0, run = 0, odd = 0, two = 0, wr = 0;
  logic [2:0] mode = 0;
  logic [8:0] wdata = 0;
  logic txd, empty, done;
  int n_tests = 0, n_fail = 0, cyc = 0, done_cnt = 0;
  bit chk_en = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  uart_tick_tx u_uart_tick_tx (
    .clk_i(clk), .rst_ni, .tick16_i(tick), .run_i(run), .mode_i(mode),
    .odd_par_i(odd), .two_stop_i(two), .wr_i(wr), .wr_data_i(wdata),
    .txd_o(txd), .buf_empty_o(empty), .tx_done_o(done)
  );

  // behavioural reference
  int   m_cnt = 0;
  bit   m_full = 0, m_busy = 0, m_done = 0;
  logic [8:0] m_buf = 0;
  bit   m_bits[$];

  function automatic bit par(input logic [8:0] d, input int n, input bit o);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    return (ones % 2 == 1) ^ o;
  endfunction

  task automatic build(input logic [8:0] d);
    int nd = 8;
    m_bits.delete();
    m_bits.push_back(1'b0);
    if (mode == 1) nd = 7;
    else if (mode == 2 || mode == 4) nd = 9;
    for (int i = 0; i < nd; i++) m_bits.push_back(d[i]);
    if (mode == 1) m_bits.push_back(par(d, 7, odd));
    if (mode == 3) m_bits.push_back(par(d, 8, odd));
    m_bits.push_back(1'b1);
    if (two) m_bits.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    bit ovf;
    if (!rst_ni) begin
      m_cnt = 0; m_full = 0; m_busy = 0; m_done = 0; m_bits.delete();
    end else begin
      ovf = run && tick && m_cnt == 15;
      if (!run) m_cnt = 0; else if (tick) m_cnt = (m_cnt + 1) % 16;
      m_done = 0;
      if (!run) begin
        m_busy = 0; m_bits.delete();
      end else if (ovf) begin
        if (m_busy) begin
          void'(m_bits.pop_front());
          if (m_bits.size() == 0) begin m_busy = 0; m_done = 1; end
        end
        if (!m_busy && m_full) begin build(m_buf); m_busy = 1; m_full = 0; end
      end
      if (wr) begin m_full = 1; m_buf = wdata; end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done) done_cnt++;
    if (chk_en) begin
      check(cur_req, "txd", txd, m_busy ? m_bits[0] : 1);
      check(cur_req, "buf_empty", empty, !m_full);
      check(cur_req, "tx_done", done, m_done);
    end
  end

  // tick every third clock
  initial forever begin
    repeat (2) @(posedge clk); #1 tick = 1;
    @(posedge clk); #1 tick = 0;
  end

  task automatic put(input logic [8:0] d);
    @(posedge clk); #1 wr = 1; wdata = d;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while ((m_busy || m_full) && g < 20000) begin @(posedge clk); g++; end
    repeat (5) @(posedge clk);
  endtask

  task automatic frame(input string req, input int md, input bit o, input bit t,
                       input logic [8:0] d);
    int d0;
    cur_req = req;
    @(posedge clk); #1 mode = md[2:0]; odd = o; two = t;
    d0 = done_cnt;
    put(d);
    @(negedge clk);
    check("R8", "empty after write", empty, 0);
    wait_idle();
    check("R9", "done pulses per frame", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "txd reset", txd, 1);
    check("R1", "empty reset", empty, 1);
    check("R1", "done reset", done, 0);
    #1 rst_ni = 1;
    chk_en = 1;
    // R2: run low, buffer held, nothing sent
    cur_req = "R2";
    put(9'h0C3);
    repeat (300) @(posedge clk);
    @(negedge clk);
    check("R2", "held while stopped", empty, 0);
    @(posedge clk); #1 run = 1;
    wait_idle();
    frame("R3", 0, 0, 1, 9'h0A5);
    frame("R4", 0, 0, 0, 9'h03C);
    frame("R4", 1, 0, 0, 9'h055);
    frame("R4", 1, 1, 1, 9'h07F);
    frame("R5", 2, 0, 0, 9'h1E1);
    frame("R5", 2, 0, 1, 9'h00F);
    frame("R6", 3, 0, 0, 9'h0B7);
    frame("R6", 3, 1, 0, 9'h0B7);
    frame("R7", 4, 0, 0, 9'h1AB);
    frame("R7", 4, 0, 1, 9'h0AB);
    frame("R11", 5, 1, 0, 9'h1F0);
    frame("R11", 7, 0, 1, 9'h10F);
    // R8: back-to-back
    begin
      int d0;
      cur_req = "R8";
      @(posedge clk); #1 mode = 3'd0; two = 0;
      d0 = done_cnt;
      put(9'h011);
      while (!empty) @(posedge clk);
      put(9'h0EE);
      while (!empty) @(posedge clk);
      put(9'h05A);
      wait_idle();
      check("R8", "back-to-back frames", done_cnt - d0, 3);
    end
    // R10: abort mid-frame, queued byte survives
    begin
      int d0;
      cur_req = "R10";
      d0 = done_cnt;
      put(9'h0F0);
      while (!empty) @(posedge clk);
      repeat (100) @(posedge clk);
      put(9'h033);
      @(posedge clk); #1 run = 0;
      repeat (60) @(posedge clk);
      @(negedge clk);
      check("R10", "line high when stopped", txd, 1);
      check("R10", "buffer kept", empty, 0);
      @(posedge clk); #1 run = 1;
      wait_idle();
      check("R10", "only resumed frame done", done_cnt - d0, 1);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule